// File: doc/BRIEF.md
# I2C Frame Acknowledge and Interrupt Flag Tracker

This block watches a two-wire serial bus from the side of a combined master and slave byte engine. It brings the clock and data wires into the system clock domain. It finds start and stop conditions and counts the nine clocks of every frame. In the first frame after a start it assembles the received address and direction bit. It then decides at the ninth clock rise whether the byte engine needs servicing.

Software uses a four-entry register window. Offset 0 is control: bit 0 enables acknowledge checking, bit 1 selects master operation and bit 2 marks that this node transmits data. Offset 1 is status: bit 0 is the interrupt flag, bit 1 is the sticky not-acknowledged bit, bit 2 is bus-busy, bit 3 means this slave was addressed and bit 4 is the captured direction bit. Writing 1 to status bit 0 clears the interrupt flag. Offsets 2 and 3 hold the two 7-bit slave addresses. Wire drivers, clock stretching, arbitration and the data shift path belong to other blocks.

Both wires pass through a two-stage synchronizer, so a wire change shows in the status on the third system clock edge after it.

Top module: `i2c_frame_mon`

## Requirements
- R1: After reset the status byte, the control byte and `irqOut` are all 0.
- R2: SDA falling while SCL is high (start) sets status bit 2 (busy); SDA rising while SCL is high (stop) clears it.
- R3: In master mode (control bit 1 = 1) every ninth SCL rise of a frame sets the interrupt flag (status bit 0, also on `irqOut`), and it is set at no other time.
- R4: In slave mode, an address frame whose first seven bits (MSB first) equal either slave address register sets the interrupt flag and status bit 3; later data frames then set the flag at their ninth rise.
- R5: In slave mode, an address frame that matches neither register sets neither the interrupt flag nor status bit 3, nor do the data frames after it, even while the sticky not-acknowledged bit is 1.
- R6: With control bit 0 = 1, a 1 sampled on SDA at the ninth rise of a frame this node transmits (master: the address frame, or data frames with control bit 2 = 1; addressed slave: data frames with control bit 2 = 1) sets status bit 1, which stays 1; an acknowledge of 0 leaves it unchanged.
- R7: While control bit 0 is 0, status bit 1 is 0 and a not-acknowledge is not recorded; setting control bit 0 back to 1 records the next one.
- R8: The interrupt flag holds until software writes 1 to status bit 0; when that write lands in the same cycle as a setting event, the flag stays 1.
- R9: The eighth bit of an address frame is latched into status bit 4 at the ninth rise.
- R10: A start in the middle of a frame restarts the clock count, so the next interrupt comes at the ninth rise after that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock wire level |
| sdaIn | input | 1 | Bus data wire level |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register offset for reads and writes |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for `regAddr` |
| irqOut | output | 1 | Interrupt flag |

## Verification
The key case is a slave address frame that matches neither register while a stale not-acknowledged bit from an earlier master transfer is still latched. A design that lets that stale bit feed the interrupt decision would raise a spurious interrupt. The bench also times a flag-clear write to land exactly on the ninth rise; a design that gives the clear priority would lose that interrupt. A restart after four bits catches a counter that does not reset on start, because such a counter would fire five clocks early. Turning acknowledge checking off and on checks both the clearing of the sticky bit and its re-arming.

// File: rtl/frame_pkg.sv
package frame_pkg;

  typedef struct packed {
    logic start;
    logic stop;
    logic dataBit;
    logic ackSlot;
    logic addrFrame;
    logic sda;
  } frameStb_t;

  localparam int ST_IRQ  = 0;
  localparam int ST_NACK = 1;
  localparam int ST_BUSY = 2;
  localparam int ST_SEL  = 3;
  localparam int ST_RW   = 4;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_STAT = 2'd1;
  localparam logic [1:0] RA_SLVA = 2'd2;
  localparam logic [1:0] RA_SLVB = 2'd3;

endpackage

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import frame_pkg::*;
#(
  parameter int FRAME_BITS  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  output frameStb_t stb
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclD, sdaD, sclS, sdaS;
  logic sclRise, startDet, stopDet;
  logic [CNT_W-1:0] bitCnt;
  logic addrFrame;

  // wire synchronizers and edge-detect history
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS     = sclSync[SYNC_STAGES-1];
  assign sdaS     = sdaSync[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;

  // frame clock counter and address-phase marker
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt    <= '0;
      addrFrame <= 1'b0;
    end else if (startDet) begin
      bitCnt    <= '0;
      addrFrame <= 1'b1;
    end else if (stopDet) begin
      bitCnt    <= '0;
      addrFrame <= 1'b0;
    end else if (sclRise) begin
      if (bitCnt == LAST) begin
        bitCnt    <= '0;
        addrFrame <= 1'b0;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    stb.start     = startDet;
    stb.stop      = stopDet;
    stb.dataBit   = sclRise && (bitCnt != LAST);
    stb.ackSlot   = sclRise && (bitCnt == LAST);
    stb.addrFrame = addrFrame;
    stb.sda       = sdaS;
  end

endmodule

// File: rtl/frame_dpath.sv
module frame_dpath
  import frame_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int REG_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  frameStb_t        stb,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic [REG_W-1:0] status,
  output logic             irq
);
  localparam int SH_W = ADDR_W + 1;

  logic ackChkEn, masterMode, txMode;
  logic [ADDR_W-1:0] slvA, slvB, rxAddr;
  logic [SH_W-1:0] shiftReg;
  logic busy, sel, rwBit, nack;
  logic wrCtrl, wrClr, hit, txFrame, irqSet;

  assign wrCtrl  = regWrEn && (regAddr == RA_CTRL);
  assign wrClr   = regWrEn && (regAddr == RA_STAT) && regWrData[ST_IRQ];
  assign rxAddr  = shiftReg[SH_W-1:1];
  assign hit     = (rxAddr == slvA) || (rxAddr == slvB);
  assign txFrame = masterMode ? (stb.addrFrame || txMode)
                              : (!stb.addrFrame && sel && txMode);
  assign irqSet  = stb.ackSlot &&
                   (masterMode || (stb.addrFrame ? hit : sel));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackChkEn   <= 1'b0;
      masterMode <= 1'b0;
      txMode     <= 1'b0;
      slvA       <= '0;
      slvB       <= '0;
    end else if (regWrEn) begin
      if (wrCtrl) begin
        ackChkEn   <= regWrData[0];
        masterMode <= regWrData[1];
        txMode     <= regWrData[2];
      end
      if (regAddr == RA_SLVA) slvA <= regWrData[ADDR_W-1:0];
      if (regAddr == RA_SLVB) slvB <= regWrData[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      busy     <= 1'b0;
      sel      <= 1'b0;
      rwBit    <= 1'b0;
      nack     <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (stb.dataBit) shiftReg <= {shiftReg[SH_W-2:0], stb.sda};
      if (stb.start) busy <= 1'b1;
      else if (stb.stop) busy <= 1'b0;
      if (stb.stop) sel <= 1'b0;
      else if (stb.ackSlot && stb.addrFrame) sel <= !masterMode && hit;
      if (stb.ackSlot && stb.addrFrame) rwBit <= shiftReg[0];
      if (!ackChkEn) nack <= 1'b0;
      else if (stb.ackSlot && txFrame && stb.sda) nack <= 1'b1;
      if (irqSet) irq <= 1'b1;
      else if (wrClr) irq <= 1'b0;
    end
  end

  always_comb begin
    status          = '0;
    status[ST_IRQ]  = irq;
    status[ST_NACK] = nack;
    status[ST_BUSY] = busy;
    status[ST_SEL]  = sel;
    status[ST_RW]   = rwBit;
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      RA_CTRL: regRdData[2:0] = {txMode, masterMode, ackChkEn};
      RA_STAT: regRdData = status;
      RA_SLVA: regRdData[ADDR_W-1:0] = slvA;
      default: regRdData[ADDR_W-1:0] = slvB;
    endcase
  end

endmodule

// File: rtl/i2c_frame_mon.sv
module i2c_frame_mon
  import frame_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int REG_W       = 8,
  parameter int FRAME_BITS  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             irqOut
);
  frameStb_t stb;
  logic [REG_W-1:0] statusVec;

  frame_ctrl #(
    .FRAME_BITS (FRAME_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .sclIn(sclIn),
    .sdaIn(sdaIn),
    .stb  (stb)
  );

  frame_dpath #(
    .ADDR_W(ADDR_W),
    .REG_W (REG_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .status   (statusVec),
    .irq      (irqOut)
  );

endmodule

// File: rtl/frame_mon_chk.sv
module frame_mon_chk
  import frame_pkg::*;
#(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input frameStb_t        stb,
  input logic             irq,
  input logic             regWrEn,
  input logic [1:0]       regAddr,
  input logic             clrBit,
  input logic [REG_W-1:0] status
);
  logic clrReq;
  assign clrReq = regWrEn && (regAddr == RA_STAT) && clrBit;

  // R2: start and stop drive the busy status
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    stb.start |=> status[ST_BUSY]);
  a_r2_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    stb.stop |=> !status[ST_BUSY]);

  // R3: the flag rises only after a ninth-clock strobe
  a_r3_irq_at_ack: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(stb.ackSlot));

  // R8: the flag holds unless a clear is written
  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !clrReq) |=> irq);

  // R6: the sticky bit rises only after a 1 in the acknowledge slot
  a_r6_nack_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[ST_NACK]) |-> $past(stb.ackSlot && stb.sda));

  // R10: bus events are mutually exclusive
  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.start, stb.stop, stb.dataBit, stb.ackSlot}));

endmodule

bind i2c_frame_mon frame_mon_chk #(.REG_W(REG_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .stb    (stb),
  .irq    (irqOut),
  .regWrEn(regWrEn),
  .regAddr(regAddr),
  .clrBit (regWrData[0]),
  .status (statusVec)
);

// File: tb/sim_i2c_frame_mon.sv
`timescale 1ns/1ps
module sim_i2c_frame_mon;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0, sclIn = 1'b1, sdaIn = 1'b1, regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd1;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic irqOut;

  i2c_frame_mon u0 (.clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut));

  int checks = 0, fails = 0, cyc = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int mScl1 = 1, mSclS = 1, mSclD = 1, mSda1 = 1, mSdaS = 1, mSdaD = 1;
  int mCnt = 0, mAddrFr = 0, mShift = 0, mBusy = 0, mSel = 0, mRw = 0;
  int mNack = 0, mIrq = 0, mAckEn = 0, mMaster = 0, mTx = 0, mSlvA = 0, mSlvB = 0;

  always @(posedge clk) begin : model
    int rise, st, sp, ack, dbit, rx, hit, txf, setI, clr;
    if (!rstN) begin
      mScl1 = 1; mSclS = 1; mSclD = 1; mSda1 = 1; mSdaS = 1; mSdaD = 1;
      mCnt = 0; mAddrFr = 0; mShift = 0; mBusy = 0; mSel = 0; mRw = 0;
      mNack = 0; mIrq = 0; mAckEn = 0; mMaster = 0; mTx = 0; mSlvA = 0; mSlvB = 0;
    end else begin
      rise = (mSclS == 1 && mSclD == 0);
      st   = (mSclS == 1 && mSclD == 1 && mSdaD == 1 && mSdaS == 0);
      sp   = (mSclS == 1 && mSclD == 1 && mSdaD == 0 && mSdaS == 1);
      ack  = rise && (mCnt == 8);
      dbit = rise && (mCnt != 8);
      rx   = (mShift >> 1) & 127;
      hit  = (rx == mSlvA) || (rx == mSlvB);
      txf  = mMaster ? (mAddrFr || mTx) : (!mAddrFr && mSel && mTx);
      setI = ack && (mMaster || (mAddrFr ? hit : mSel));
      clr  = regWrEn && regAddr == 1 && regWrData[0];
      if (!mAckEn) mNack = 0;
      else if (ack && txf && mSdaS) mNack = 1;
      if (setI) mIrq = 1; else if (clr) mIrq = 0;
      if (ack && mAddrFr) mRw = mShift & 1;
      if (sp) mSel = 0; else if (ack && mAddrFr) mSel = !mMaster && hit;
      if (dbit) mShift = ((mShift << 1) | mSdaS) & 255;
      if (st) mBusy = 1; else if (sp) mBusy = 0;
      if (st) begin mCnt = 0; mAddrFr = 1; end
      else if (sp) begin mCnt = 0; mAddrFr = 0; end
      else if (rise) begin
        if (mCnt == 8) begin mCnt = 0; mAddrFr = 0; end else mCnt++;
      end
      if (regWrEn) begin
        if (regAddr == 0) begin mAckEn = regWrData[0]; mMaster = regWrData[1]; mTx = regWrData[2]; end
        if (regAddr == 2) mSlvA = regWrData[6:0];
        if (regAddr == 3) mSlvB = regWrData[6:0];
      end
      mSclD = mSclS; mSclS = mScl1; mScl1 = sclIn;
      mSdaD = mSdaS; mSdaS = mSda1; mSda1 = sdaIn;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      check("R3 irqOut", irqOut, mIrq);
      if (regAddr == 1) begin
        check("R8 irq bit", regRdData[0], mIrq);
        check("R6 nack bit", regRdData[1], mNack);
        check("R2 busy bit", regRdData[2], mBusy);
        check("R4 addressed bit", regRdData[3], mSel);
        check("R9 rw bit", regRdData[4], mRw);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=finished", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic pins(input logic s, input logic d);
    @(negedge clk); #1 sclIn = s; sdaIn = d;
    repeat (4) @(negedge clk);
  endtask

  task automatic i2cStart();
    pins(sclIn, 1'b1); pins(1'b1, 1'b1); pins(1'b1, 1'b0); pins(1'b0, 1'b0);
  endtask

  task automatic i2cStop();
    pins(1'b0, 1'b0); pins(1'b1, 1'b0); pins(1'b1, 1'b1);
  endtask

  task automatic sendBit(input logic b);
    pins(1'b0, b); pins(1'b1, b); pins(1'b0, b);
  endtask

  task automatic sendByte(input logic [7:0] v, input logic ackBit);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    sendBit(ackBit);
  endtask

  // ninth clock with a flag-clear write landing on the same edge
  task automatic sendByteCollide(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    pins(1'b0, 1'b0);
    @(negedge clk); #1 sclIn = 1'b1;
    @(negedge clk);
    @(negedge clk); #1 regWrEn = 1'b1; regWrData = 8'h01; regAddr = 2'd1;
    @(negedge clk); #1 regWrEn = 1'b0;
    repeat (3) @(negedge clk);
    pins(1'b0, 1'b0);
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1 regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); #1 regWrEn = 1'b0; regAddr = 2'd1;
    @(negedge clk);
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); #1 regAddr = a;
    @(negedge clk); v = regRdData;
    #1 regAddr = 2'd1;
  endtask

  task automatic clearIrq();
    regWrite(2'd1, 8'h01);
  endtask

  logic [7:0] rd;

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R1 status after reset", regRdData, 0);
    check("R1 irqOut after reset", irqOut, 0);
    readReg(2'd0, rd); check("R1 control after reset", rd, 0);

    regWrite(2'd2, 8'h2A);
    regWrite(2'd3, 8'h51);
    readReg(2'd2, rd); check("R4 slave address A", rd, 8'h2A);

    // master transmit
    regWrite(2'd0, 8'h07);
    check("R2 idle after master set", regRdData[2], 0);
    i2cStart();
    check("R2 busy after start", regRdData[2], 1);
    sendByte(8'hA0, 1'b0);
    check("R3 irq after master address frame", irqOut, 1);
    check("R6 ack 0 leaves nack clear", regRdData[1], 0);
    clearIrq();
    check("R8 irq cleared by write", irqOut, 0);
    sendByte(8'h3C, 1'b1);
    check("R3 irq after master data frame", irqOut, 1);
    check("R6 nack latched", regRdData[1], 1);
    clearIrq();
    sendByte(8'h5A, 1'b0);
    check("R6 nack stays after later ack", regRdData[1], 1);
    clearIrq();
    sendByteCollide(8'h11);
    check("R8 set wins over same-cycle clear", irqOut, 1);
    clearIrq();
    check("R8 irq cleared", irqOut, 0);
    i2cStop();
    check("R2 idle after stop", regRdData[2], 0);

    // slave, mismatching address with stale nack
    regWrite(2'd0, 8'h01);
    i2cStart();
    sendByte(8'h66, 1'b0);
    check("R5 no irq on mismatch", irqOut, 0);
    check("R5 stale nack still set", regRdData[1], 1);
    check("R5 not addressed", regRdData[3], 0);
    sendByte(8'hFF, 1'b0);
    check("R5 no irq on data after mismatch", irqOut, 0);
    i2cStop();

    // acknowledge-check enable
    regWrite(2'd0, 8'h00);
    check("R7 nack cleared by enable 0", regRdData[1], 0);
    regWrite(2'd0, 8'h06);
    i2cStart();
    sendByte(8'h12, 1'b1);
    check("R7 nack ignored while disabled", regRdData[1], 0);
    clearIrq();
    i2cStop();
    regWrite(2'd0, 8'h07);
    i2cStart();
    sendByte(8'h12, 1'b1);
    check("R7 nack recorded after re-arm", regRdData[1], 1);
    clearIrq();
    i2cStop();
    regWrite(2'd0, 8'h00);

    // slave match on address A, read direction
    regWrite(2'd0, 8'h01);
    i2cStart();
    sendByte(8'h55, 1'b0);
    check("R4 irq on match A", irqOut, 1);
    check("R4 addressed on match A", regRdData[3], 1);
    check("R9 rw captured 1", regRdData[4], 1);
    clearIrq();
    sendByte(8'hC3, 1'b0);
    check("R4 irq on data after match", irqOut, 1);
    clearIrq();
    i2cStop();
    check("R4 addressed cleared by stop", regRdData[3], 0);

    // slave match on address B, write direction
    i2cStart();
    sendByte(8'hA2, 1'b0);
    check("R4 irq on match B", irqOut, 1);
    check("R9 rw captured 0", regRdData[4], 0);
    clearIrq();
    i2cStop();

    // repeated start in the middle of a frame
    i2cStart();
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b0);
    i2cStart();
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b0); sendBit(1'b0);
    check("R10 no early irq after restart", irqOut, 0);
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b0); sendBit(1'b0);
    check("R10 irq at ninth rise after restart", irqOut, 1);
    check("R10 addressed after restart", regRdData[3], 1);
    clearIrq();
    i2cStop();

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule